// File: doc/BRIEF.md
# Vector Chaining Issue Controller

This block decides, one request at a time, whether a decoded vector instruction may start. It keeps one tracker per vector functional unit (add, shift, logical). Each tracker records the operation running on that unit: its destination register, the vector registers it reads, its vector length, and how many clocks have passed since it started. From these trackers the block works out whether the unit is free and whether the registers involved are safe to use. It also decides whether a source register that is still being produced can be read from the live result stream. Reading that stream lets a dependent operation start before its producer has finished, which is called chaining.

The arithmetic itself is not modelled. Each unit is a fixed-latency delay line. Once the latency has passed, the block emits one write strobe per element on that unit's lane, carrying the destination register and the element index. A requester holds its instruction on the inputs. `o_issue` is combinational and marks the cycle whose closing clock edge accepts the instruction. `o_chained` and `o_chain_lag` report whether the start was chained and at which producer age it happened.

Top module: `vchain_issue_ctrl`

## Requirements
- R1: The 6-bit vector length field selects 1 to 63 elements directly, and the code 0 selects 64 elements. An accepted operation emits exactly that many write strobes.
- R2: If an operation is accepted in cycle t, element e is strobed in cycle t+LAT+e, with the element index e and the destination register. Lane 0 is add (LAT 3), lane 1 is shift (LAT 4) and lane 2 is logical (LAT 2). The lane number equals the unit code.
- R3: After an operation of length VL is accepted in cycle t, its unit accepts nothing before cycle t+VL+4.
- R4: A request whose destination equals the destination or a vector source of an operation still writing waits until the cycle after that operation's last strobe. Sharing only source registers with such an operation causes no wait.
- R5: A request that reads the destination of an operation still writing is accepted with `o_chained`=1 when the producer's age is between LAT and LAT+2 inclusive. The age is the number of cycles since the producer's acceptance cycle. `o_chain_lag` then equals that age.
- R6: A dependent request first presented when the producer's age is beyond LAT+2 waits until cycle t+LAT+VL of the producer and is then accepted with `o_chained`=0.
- R7: A dependent request presented before the producer's age reaches LAT waits and is accepted, chained, in the cycle when the age equals LAT.
- R8: When the scalar flag is set, the first source index is ignored for every hazard check.
- R9: Unit code 3 is never accepted. At most one instruction is accepted per clock.
- R10: While reset is high, `o_issue` is 0 and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_req_valid | input | 1 | An instruction is presented |
| i_fu | input | 2 | Unit code: 0 add, 1 shift, 2 logical, 3 none |
| i_src_a | input | $clog2(NVREG) | First source register index |
| i_src_a_scalar | input | 1 | First operand is a scalar, so i_src_a is not a vector register |
| i_src_b | input | $clog2(NVREG) | Second (vector) source register |
| i_dst | input | $clog2(NVREG) | Destination vector register |
| i_vlen | input | $clog2(MAXVL) | Vector length, 0 meaning MAXVL |
| o_issue | output | 1 | The instruction is accepted at the next edge |
| o_chained | output | 1 | The acceptance reads a live result stream |
| o_chain_lag | output | 8 | Producer age at the chained start, else 0 |
| o_wr_valid | output | 3 | Per-lane element write strobe |
| o_wr_reg | output | 3*$clog2(NVREG) | Per-lane destination register |
| o_wr_elem | output | 3*$clog2(MAXVL) | Per-lane element index |

## Verification
The bench probes both edges of the chain window. It presents one dependent request exactly at age LAT+2 and another one cycle later. A window that is off by one would either refuse the first or chain the second onto a stream it has already passed. It presents a dependent request right after its producer starts, so a design that chains too early would read elements that do not exist yet. It checks that a unit stays blocked for exactly VL+4 cycles, and that the length code 0 gives 64 strobes rather than none. It also checks that only a destination conflict stalls a request, never a shared source, and that a scalar operand index never creates a false dependency.

// File: rtl/vchain_pkg.sv
package vchain_pkg;
  localparam int NFU = 3;
  typedef enum logic [1:0] {
    FU_ADD   = 2'd0,
    FU_SHIFT = 2'd1,
    FU_LOGIC = 2'd2,
    FU_NONE  = 2'd3
  } fu_e;
endpackage

// File: rtl/vchain_unit_track.sv
module vchain_unit_track #(
  parameter int LAT         = 3,
  parameter int NVREG       = 8,
  parameter int VREG_W      = 3,
  parameter int VL_W        = 7,
  parameter int EL_W        = 6,
  parameter int AGE_W       = 8,
  parameter int BUSY_TAIL   = 4,
  parameter int CHAIN_SLACK = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              i_start,
  input  logic [VREG_W-1:0] i_dst,
  input  logic [NVREG-1:0]  i_src_mask,
  input  logic [VL_W-1:0]   i_vl,
  output logic              o_fu_busy,
  output logic              o_reg_busy,
  output logic [VREG_W-1:0] o_dst,
  output logic [NVREG-1:0]  o_src_mask,
  output logic              o_chain_open,
  output logic [AGE_W-1:0]  o_age,
  output logic              o_wr_valid,
  output logic [VREG_W-1:0] o_wr_reg,
  output logic [EL_W-1:0]   o_wr_elem
);
  localparam logic [AGE_W-1:0] LAT_A  = AGE_W'(LAT);
  localparam logic [AGE_W-1:0] TAIL_A = AGE_W'(BUSY_TAIL);
  localparam logic [AGE_W-1:0] SLK_A  = AGE_W'(LAT + CHAIN_SLACK);

  logic              active_q;
  logic [AGE_W-1:0]  age_q;
  logic [VREG_W-1:0] dst_q;
  logic [NVREG-1:0]  src_q;
  logic [VL_W-1:0]   vl_q;
  logic [AGE_W-1:0]  free_at;
  logic [AGE_W-1:0]  done_at;

  assign free_at = AGE_W'(vl_q) + TAIL_A;
  assign done_at = AGE_W'(vl_q) + LAT_A;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      age_q    <= '0;
      dst_q    <= '0;
      src_q    <= '0;
      vl_q     <= '0;
    end else if (i_start) begin
      active_q <= 1'b1;
      age_q    <= AGE_W'(1);
      dst_q    <= i_dst;
      src_q    <= i_src_mask;
      vl_q     <= i_vl;
    end else if (active_q) begin
      if (age_q >= free_at) active_q <= 1'b0;
      else                  age_q    <= age_q + AGE_W'(1);
    end
  end

  assign o_fu_busy    = active_q && (age_q < free_at);
  assign o_reg_busy   = active_q && (age_q < done_at);
  assign o_chain_open = o_reg_busy && (age_q >= LAT_A) && (age_q <= SLK_A);
  assign o_dst        = dst_q;
  assign o_src_mask   = src_q;
  assign o_age        = age_q;
  assign o_wr_valid   = active_q && (age_q >= LAT_A) && (age_q < done_at);
  assign o_wr_reg     = dst_q;
  assign o_wr_elem    = EL_W'(age_q - LAT_A);

  p_start_free_r3: assert property (@(posedge clk) disable iff (rst)
    i_start |-> !o_fu_busy);
  p_first_elem_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(o_wr_valid) |-> (o_wr_elem == '0));
  p_elem_step_r2: assert property (@(posedge clk) disable iff (rst)
    (o_wr_valid && $past(o_wr_valid)) |-> (o_wr_elem == EL_W'($past(o_wr_elem) + 1'b1)));
endmodule

// File: rtl/vchain_hazard.sv
module vchain_hazard
  import vchain_pkg::*;
#(
  parameter int NVREG  = 8,
  parameter int VREG_W = 3,
  parameter int AGE_W  = 8
) (
  input  logic                         i_req_valid,
  input  logic [1:0]                   i_fu,
  input  logic [VREG_W-1:0]            i_src_a,
  input  logic                         i_src_a_scalar,
  input  logic [VREG_W-1:0]            i_src_b,
  input  logic [VREG_W-1:0]            i_dst,
  input  logic [NFU-1:0]               i_u_fu_busy,
  input  logic [NFU-1:0]               i_u_reg_busy,
  input  logic [NFU-1:0]               i_u_chain_open,
  input  logic [NFU-1:0][VREG_W-1:0]   i_u_dst,
  input  logic [NFU-1:0][NVREG-1:0]    i_u_src,
  input  logic [NFU-1:0][AGE_W-1:0]    i_u_age,
  output logic                         o_ok,
  output logic                         o_chained,
  output logic [AGE_W-1:0]             o_lag,
  output logic [NVREG-1:0]             o_src_mask
);
  logic             block;
  logic             chain;
  logic [AGE_W-1:0] lag;
  logic [NVREG-1:0] req_src;

  always_comb begin
    req_src = '0;
    if (!i_src_a_scalar) req_src[i_src_a] = 1'b1;
    req_src[i_src_b] = 1'b1;
    block = (i_fu == FU_NONE);
    chain = 1'b0;
    lag   = '0;
    for (int u = 0; u < NFU; u++) begin
      if ((i_fu == 2'(u)) && i_u_fu_busy[u]) block = 1'b1;
      if (i_u_reg_busy[u]) begin
        if ((i_u_dst[u] == i_dst) || i_u_src[u][i_dst]) block = 1'b1;
        if (req_src[i_u_dst[u]]) begin
          if (i_u_chain_open[u]) begin
            chain = 1'b1;
            if (i_u_age[u] > lag) lag = i_u_age[u];
          end else begin
            block = 1'b1;
          end
        end
      end
    end
  end

  assign o_ok       = i_req_valid && !block;
  assign o_chained  = o_ok && chain;
  assign o_lag      = o_chained ? lag : '0;
  assign o_src_mask = req_src;
endmodule

// File: rtl/vchain_issue_ctrl.sv
module vchain_issue_ctrl
  import vchain_pkg::*;
#(
  parameter int NVREG       = 8,
  parameter int MAXVL       = 64,
  parameter int LAT_ADD     = 3,
  parameter int LAT_SHIFT   = 4,
  parameter int LAT_LOGIC   = 2,
  parameter int BUSY_TAIL   = 4,
  parameter int CHAIN_SLACK = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             i_req_valid,
  input  logic [1:0]                       i_fu,
  input  logic [$clog2(NVREG)-1:0]         i_src_a,
  input  logic                             i_src_a_scalar,
  input  logic [$clog2(NVREG)-1:0]         i_src_b,
  input  logic [$clog2(NVREG)-1:0]         i_dst,
  input  logic [$clog2(MAXVL)-1:0]         i_vlen,
  output logic                             o_issue,
  output logic                             o_chained,
  output logic [7:0]                       o_chain_lag,
  output logic [NFU-1:0]                   o_wr_valid,
  output logic [NFU*$clog2(NVREG)-1:0]     o_wr_reg,
  output logic [NFU*$clog2(MAXVL)-1:0]     o_wr_elem
);
  localparam int VREG_W = $clog2(NVREG);
  localparam int EL_W   = $clog2(MAXVL);
  localparam int VL_W   = EL_W + 1;
  localparam int AGE_W  = 8;

  logic [VL_W-1:0]                 vl_full;
  logic                            ok_w;
  logic                            chained_w;
  logic [AGE_W-1:0]                lag_w;
  logic [NVREG-1:0]                req_src;
  logic [NFU-1:0]                  u_start;
  logic [NFU-1:0]                  u_fu_busy;
  logic [NFU-1:0]                  u_reg_busy;
  logic [NFU-1:0]                  u_chain_open;
  logic [NFU-1:0][VREG_W-1:0]      u_dst;
  logic [NFU-1:0][NVREG-1:0]       u_src;
  logic [NFU-1:0][AGE_W-1:0]       u_age;
  logic [NFU-1:0][VREG_W-1:0]      u_wr_reg;
  logic [NFU-1:0][EL_W-1:0]        u_wr_elem;

  assign vl_full = (i_vlen == '0) ? VL_W'(MAXVL) : VL_W'(i_vlen);

  vchain_hazard #(.NVREG(NVREG), .VREG_W(VREG_W), .AGE_W(AGE_W)) u_hazard (
    .i_req_valid   (i_req_valid),
    .i_fu          (i_fu),
    .i_src_a       (i_src_a),
    .i_src_a_scalar(i_src_a_scalar),
    .i_src_b       (i_src_b),
    .i_dst         (i_dst),
    .i_u_fu_busy   (u_fu_busy),
    .i_u_reg_busy  (u_reg_busy),
    .i_u_chain_open(u_chain_open),
    .i_u_dst       (u_dst),
    .i_u_src       (u_src),
    .i_u_age       (u_age),
    .o_ok          (ok_w),
    .o_chained     (chained_w),
    .o_lag         (lag_w),
    .o_src_mask    (req_src)
  );

  assign o_issue     = ok_w && !rst;
  assign o_chained   = chained_w && !rst;
  assign o_chain_lag = rst ? '0 : lag_w;

  for (genvar g = 0; g < NFU; g++) begin : g_unit
    localparam int L = (g == int'(FU_ADD))   ? LAT_ADD :
                       (g == int'(FU_SHIFT)) ? LAT_SHIFT : LAT_LOGIC;
    assign u_start[g] = o_issue && (i_fu == 2'(g));

    vchain_unit_track #(
      .LAT(L), .NVREG(NVREG), .VREG_W(VREG_W), .VL_W(VL_W), .EL_W(EL_W),
      .AGE_W(AGE_W), .BUSY_TAIL(BUSY_TAIL), .CHAIN_SLACK(CHAIN_SLACK)
    ) u_track (
      .clk         (clk),
      .rst         (rst),
      .i_start     (u_start[g]),
      .i_dst       (i_dst),
      .i_src_mask  (req_src),
      .i_vl        (vl_full),
      .o_fu_busy   (u_fu_busy[g]),
      .o_reg_busy  (u_reg_busy[g]),
      .o_dst       (u_dst[g]),
      .o_src_mask  (u_src[g]),
      .o_chain_open(u_chain_open[g]),
      .o_age       (u_age[g]),
      .o_wr_valid  (o_wr_valid[g]),
      .o_wr_reg    (u_wr_reg[g]),
      .o_wr_elem   (u_wr_elem[g])
    );

    assign o_wr_reg[g*VREG_W +: VREG_W] = u_wr_reg[g];
    assign o_wr_elem[g*EL_W +: EL_W]    = u_wr_elem[g];
  end

  for (genvar a = 0; a < NFU; a++) begin : g_pair_a
    for (genvar b = a + 1; b < NFU; b++) begin : g_pair_b
      p_wr_distinct_r4: assert property (@(posedge clk) disable iff (rst)
        !(o_wr_valid[a] && o_wr_valid[b] && (u_wr_reg[a] == u_wr_reg[b])));
    end
  end

  p_rst_quiet_r10: assert property (@(posedge clk)
    rst |-> (!o_issue && !o_chained));
endmodule

// File: tb/vchain_issue_ctrl_bench.sv
`timescale 1ns/1ps
module vchain_issue_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic [1:0] fu  = 2'd0;
  logic [2:0] sa  = 3'd0;
  logic       sc  = 1'b0;
  logic [2:0] sb  = 3'd0;
  logic [2:0] dst = 3'd0;
  logic [5:0] vl  = 6'd1;
  logic       o_issue, o_chained;
  logic [7:0] o_chain_lag;
  logic [2:0] o_wr_valid;
  logic [8:0] o_wr_reg;
  logic [17:0] o_wr_elem;

  vchain_issue_ctrl u_vchain_issue_ctrl (
    .clk(clk), .rst(rst), .i_req_valid(req), .i_fu(fu), .i_src_a(sa),
    .i_src_a_scalar(sc), .i_src_b(sb), .i_dst(dst), .i_vlen(vl),
    .o_issue(o_issue), .o_chained(o_chained), .o_chain_lag(o_chain_lag),
    .o_wr_valid(o_wr_valid), .o_wr_reg(o_wr_reg), .o_wr_elem(o_wr_elem)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  int first_c [3];
  int cnt [3];
  int seq_err [3];
  int wreg [3];
  int strobes = 0;

  always @(negedge clk) begin
    for (int l = 0; l < 3; l++) begin
      if (!rst && o_wr_valid[l]) begin
        strobes++;
        if (o_wr_elem[l*6 +: 6] == 6'd0) begin
          first_c[l] = cyc;
          cnt[l]     = 1;
          wreg[l]    = int'(o_wr_reg[l*3 +: 3]);
        end else begin
          if (int'(o_wr_elem[l*6 +: 6]) != cnt[l]) seq_err[l]++;
          cnt[l]++;
        end
      end
    end
  end

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    n_run++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    for (int l = 0; l < 3; l++) begin
      first_c[l] = -1; cnt[l] = 0; seq_err[l] = 0; wreg[l] = -1;
    end
    strobes = 0;
  endtask

  // Called just after a falling edge; returns just after a falling edge.
  task automatic send(input logic [1:0] f, input logic [2:0] a, input logic s,
                      input logic [2:0] b, input logic [2:0] d, input logic [5:0] v,
                      output int t_iss, output int ch, output int lag);
    fu = f; sa = a; sc = s; sb = b; dst = d; vl = v; req = 1'b1;
    t_iss = -1; ch = -1; lag = -1;
    for (int w = 0; w < 400 && t_iss < 0; w++) begin
      #1;
      if (o_issue) begin
        t_iss = cyc; ch = int'(o_chained); lag = int'(o_chain_lag);
        @(posedge clk);
        #1 req = 1'b0;
      end
      @(negedge clk);
    end
    req = 1'b0;
  endtask

  task automatic idle(); repeat (100) @(negedge clk); endtask

  // {unit, dst, vlen code, expected latency, expected count}
  localparam logic [21:0] TBL [4] = '{
    {2'd0, 3'd3, 6'd5,  4'd3, 7'd5},
    {2'd1, 3'd4, 6'd0,  4'd4, 7'd64},
    {2'd2, 3'd7, 6'd1,  4'd2, 7'd1},
    {2'd0, 3'd0, 6'd63, 4'd3, 7'd63}
  };

  initial begin : main
    int tp, tc, ch, lag, hits;
    // R10: reset state
    fu = 2'd0; dst = 3'd1; sb = 3'd2; req = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(o_issue == 1'b0, "R10 issue in reset", int'(o_issue), 0);
    chk(o_wr_valid == 3'b000, "R10 strobes in reset", int'(o_wr_valid), 0);
    req = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1/R2: isolated operations from the table
    for (int i = 0; i < 4; i++) begin
      logic [1:0] tf; logic [2:0] td; logic [5:0] tv; int tl, tn;
      tf = TBL[i][21:20]; td = TBL[i][19:17]; tv = TBL[i][16:11];
      tl = int'(TBL[i][10:7]); tn = int'(TBL[i][6:0]);
      clear_mon();
      send(tf, 3'd1, 1'b0, 3'd2, td, tv, tp, ch, lag);
      idle();
      chk(first_c[tf] - tp == tl, "R2 first strobe delay", first_c[tf] - tp, tl);
      chk(cnt[tf] == tn, "R1 strobe count", cnt[tf], tn);
      chk(wreg[tf] == int'(td), "R2 strobe register", wreg[tf], int'(td));
      chk(seq_err[tf] == 0, "R2 element order", seq_err[tf], 0);
    end

    // R3: same unit blocked for VL+4
    send(2'd0, 3'd2, 1'b0, 3'd3, 3'd1, 6'd10, tp, ch, lag);
    send(2'd0, 3'd5, 1'b0, 3'd6, 3'd4, 6'd3, tc, ch, lag);
    chk(tc - tp == 14, "R3 unit reuse delay", tc - tp, 14);
    chk(ch == 0, "R3 not chained", ch, 0);
    idle();

    // R7: early dependent request chains at age LAT (shift LAT 4)
    send(2'd1, 3'd2, 1'b0, 3'd3, 3'd1, 6'd20, tp, ch, lag);
    send(2'd0, 3'd1, 1'b0, 3'd4, 3'd5, 6'd20, tc, ch, lag);
    chk(tc - tp == 4, "R7 chain start", tc - tp, 4);
    chk(ch == 1, "R7 chained", ch, 1);
    chk(lag == 4, "R5 lag at LAT", lag, 4);
    idle();

    // R5: request at age LAT+2 (logical LAT 2) still chains
    send(2'd2, 3'd2, 1'b0, 3'd3, 3'd6, 6'd30, tp, ch, lag);
    repeat (3) @(negedge clk);
    send(2'd0, 3'd0, 1'b0, 3'd6, 3'd7, 6'd8, tc, ch, lag);
    chk(tc - tp == 4, "R5 window edge issue", tc - tp, 4);
    chk(ch == 1, "R5 window edge chained", ch, 1);
    chk(lag == 4, "R5 window edge lag", lag, 4);
    idle();

    // R6: request at age LAT+3 waits for the last write
    send(2'd2, 3'd2, 1'b0, 3'd3, 3'd6, 6'd30, tp, ch, lag);
    repeat (4) @(negedge clk);
    send(2'd1, 3'd6, 1'b0, 3'd0, 3'd7, 6'd8, tc, ch, lag);
    chk(tc - tp == 32, "R6 missed window delay", tc - tp, 32);
    chk(ch == 0, "R6 not chained", ch, 0);
    idle();

    // R4: destination equals a source in flight
    send(2'd0, 3'd2, 1'b0, 3'd3, 3'd1, 6'd8, tp, ch, lag);
    send(2'd1, 3'd4, 1'b0, 3'd5, 3'd2, 6'd4, tc, ch, lag);
    chk(tc - tp == 11, "R4 dst on busy source", tc - tp, 11);
    idle();
    // R4: shared sources only
    send(2'd0, 3'd2, 1'b0, 3'd3, 3'd1, 6'd8, tp, ch, lag);
    send(2'd2, 3'd2, 1'b0, 3'd3, 3'd4, 6'd4, tc, ch, lag);
    chk(tc - tp == 1, "R4 shared source no wait", tc - tp, 1);
    idle();
    // R4: same destination
    send(2'd0, 3'd2, 1'b0, 3'd3, 3'd1, 6'd8, tp, ch, lag);
    send(2'd2, 3'd4, 1'b0, 3'd5, 3'd1, 6'd4, tc, ch, lag);
    chk(tc - tp == 11, "R4 same destination", tc - tp, 11);
    idle();

    // R8: scalar flag hides the first source index
    send(2'd0, 3'd2, 1'b0, 3'd3, 3'd1, 6'd16, tp, ch, lag);
    repeat (9) @(negedge clk);
    send(2'd2, 3'd1, 1'b1, 3'd5, 3'd6, 6'd4, tc, ch, lag);
    chk(tc - tp == 10, "R8 scalar no hazard", tc - tp, 10);
    chk(ch == 0, "R8 scalar not chained", ch, 0);
    idle();

    // R9: unit code 3 never accepted
    clear_mon();
    fu = 2'd3; dst = 3'd2; sa = 3'd0; sb = 3'd1; sc = 1'b0; vl = 6'd4; req = 1'b1;
    hits = 0;
    for (int k = 0; k < 10; k++) begin
      #1; if (o_issue) hits++;
      @(negedge clk);
    end
    req = 1'b0;
    idle();
    chk(hits == 0, "R9 code 3 accepted", hits, 0);
    chk(strobes == 0, "R9 code 3 strobes", strobes, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule